// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the byte-addressed program counter of a small 32-bit load/store processor and works out the address of the following instruction on every clock. It reads the instruction word that is currently executing, together with the two register operand values that an outside register file has already read for it. From these it picks one of four ways forward: step to the next word, take a PC-relative conditional branch, take an absolute jump inside the current 256 MB region, or jump to an address held in a register.

Branch offsets are signed word counts and are added to the address of the instruction after the branch, not to the branch itself. Region jumps keep the top four bits of that following address and replace the rest with a 26-bit word index. The following address is also driven on a link output, so the register file can store a return address for jump-and-link. A stall input freezes the counter. A synchronous reset loads a reset vector set by a parameter.

The decision is a four-way flow choice named in the design: FLOW_SEQ (step by one word), FLOW_BRANCH (PC-relative target), FLOW_REGION (spliced region target) and FLOW_REG (register target). The choice is made again on every clock and nothing is kept between instructions, so each flow is reached directly from any other.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc` is loaded with the parameter `RESET_VEC` (default 0x0040_0000). This happens even if `stall` is high.
- R2: While `rst` is low and `stall` is high at a rising edge, `pc` keeps its value, whatever the instruction is.
- R3: Any opcode in `instr[31:26]` other than 2, 3, 4 and 5, and any opcode 0 word whose function field `instr[5:0]` is not 8, advances `pc` to `pc + 4`.
- R4: `link_addr` always equals `pc + 4` (modulo 2^32), with no clock delay.
- R5: Opcode 4 (branch when equal) gives `pc + 4 + 4*sext(instr[15:0])` when `rs_val == rt_val`, and `pc + 4` otherwise.
- R6: Opcode 5 (branch when not equal) gives `pc + 4 + 4*sext(instr[15:0])` when `rs_val != rt_val`, and `pc + 4` otherwise. A negative offset gives a backward branch.
- R7: Opcodes 2 (jump) and 3 (jump-and-link) give `{(pc+4)[31:28], instr[25:0], 2'b00}`. The region is taken from `pc + 4`, so it wraps to region 0 when `pc` is 0xFFFF_FFFC.
- R8: Opcode 0 with function field 8 (register jump) gives `rs_val` with its two low bits cleared.
- R9: Bits 1:0 of `pc` are 00 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | High holds the program counter |
| instr | input | 32 | Instruction word now executing |
| rs_val | input | 32 | Value of the first source register (field 25:21) |
| rt_val | input | 32 | Value of the second source register (field 20:16) |
| pc | output | 32 | Current program counter |
| link_addr | output | 32 | Address of the following instruction, pc + 4 |

## Verification
The only state in the block is the program counter, so a wrong next-address choice shows on `pc` at the very next clock edge. It also shows on `link_addr` at once, because that output is computed from `pc` without a register. A wrong flow choice, a wrong offset scale or a wrong region splice therefore appears one cycle after the instruction that caused it. After that the error carries into every later address, which lets the cycle-by-cycle reference comparison find the exact vector that went wrong.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;
    localparam int XLEN     = 32;
    localparam int OP_W     = 6;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;
    localparam int IDX_W    = 26;
    localparam int REGION_W = XLEN - IDX_W - 2;
    localparam int STEP     = 4;

    localparam logic [OP_W-1:0]    OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0]    OPC_JMP     = 6'd2;
    localparam logic [OP_W-1:0]    OPC_JMPL    = 6'd3;
    localparam logic [OP_W-1:0]    OPC_BEQ     = 6'd4;
    localparam logic [OP_W-1:0]    OPC_BNE     = 6'd5;
    localparam logic [FUNCT_W-1:0] FN_JREG     = 6'd8;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_BRANCH,
        FLOW_REGION,
        FLOW_REG
    } flow_e;
endpackage

// File: rtl/pcnu_decode.sv
module pcnu_decode
    import pcnu_pkg::*;
(
    input  logic [XLEN-1:0]  instr,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output flow_e            flow,
    output logic [XLEN-1:0]  imm_ext,
    output logic [IDX_W-1:0] jidx
);
    logic [OP_W-1:0]    opcode;
    logic [FUNCT_W-1:0] funct;
    logic [IMM_W-1:0]   imm;
    logic               same;

    assign opcode  = instr[XLEN-1 -: OP_W];
    assign funct   = instr[FUNCT_W-1:0];
    assign imm     = instr[IMM_W-1:0];
    assign jidx    = instr[IDX_W-1:0];
    assign imm_ext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign same    = (rs_val == rt_val);

    always_comb begin
        flow = FLOW_SEQ;
        unique case (opcode)
            OPC_JMP, OPC_JMPL: flow = FLOW_REGION;
            OPC_BEQ:           flow = same  ? FLOW_BRANCH : FLOW_SEQ;
            OPC_BNE:           flow = !same ? FLOW_BRANCH : FLOW_SEQ;
            OPC_SPECIAL:       flow = (funct == FN_JREG) ? FLOW_REG : FLOW_SEQ;
            default:           flow = FLOW_SEQ;
        endcase
    end
endmodule

// File: rtl/pcnu_target.sv
module pcnu_target
    import pcnu_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  flow_e            flow,
    input  logic [XLEN-1:0]  imm_ext,
    input  logic [IDX_W-1:0] jidx,
    input  logic [XLEN-1:0]  rs_val,
    output logic [XLEN-1:0]  pc_plus4,
    output logic [XLEN-1:0]  next_pc
);
    localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(STEP) - XLEN'(1));

    logic [XLEN-1:0] branch_tgt;
    logic [XLEN-1:0] region_tgt;
    logic [XLEN-1:0] reg_tgt;

    assign pc_plus4   = pc + XLEN'(STEP);
    assign branch_tgt = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign region_tgt = {pc_plus4[XLEN-1 -: REGION_W], jidx, 2'b00};
    assign reg_tgt    = rs_val & ALIGN_MASK;

    always_comb begin
        next_pc = pc_plus4;
        unique case (flow)
            FLOW_SEQ:    next_pc = pc_plus4;
            FLOW_BRANCH: next_pc = branch_tgt;
            FLOW_REGION: next_pc = region_tgt;
            FLOW_REG:    next_pc = reg_tgt;
            default:     next_pc = pc_plus4;
        endcase
    end
endmodule

// File: rtl/pcnu_pc_reg.sv
module pcnu_pc_reg
    import pcnu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stall,
    input  logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] pc_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_VEC;
        end else if (!stall) begin
            pc_q <= next_pc;
        end
    end
endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
    import pcnu_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall,
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] pc,
    output logic [31:0] link_addr
);
    flow_e            flow;
    logic [XLEN-1:0]  imm_ext;
    logic [IDX_W-1:0] jidx;
    logic [XLEN-1:0]  next_pc;
    logic [XLEN-1:0]  pc_q;

    pcnu_decode u_decode (
        .instr   (instr),
        .rs_val  (rs_val),
        .rt_val  (rt_val),
        .flow    (flow),
        .imm_ext (imm_ext),
        .jidx    (jidx)
    );

    pcnu_target u_target (
        .pc       (pc_q),
        .flow     (flow),
        .imm_ext  (imm_ext),
        .jidx     (jidx),
        .rs_val   (rs_val),
        .pc_plus4 (link_addr),
        .next_pc  (next_pc)
    );

    pcnu_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc_reg (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .next_pc (next_pc),
        .pc_q    (pc_q)
    );

    assign pc = pc_q;
endmodule

// File: rtl/pcnu_checker.sv
module pcnu_checker #(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic [31:0] pc,
    input logic [31:0] link_addr
);
    logic [31:0] seq_c;
    logic [5:0]  op;
    logic        is_ctl;

    assign seq_c  = pc + 32'd4;
    assign op     = instr[31:26];
    assign is_ctl = (op == 6'd2) || (op == 6'd3) || (op == 6'd4) || (op == 6'd5)
                  || ((op == 6'd0) && (instr[5:0] == 6'd8));

    AST_RESET_VEC: assert property (@(posedge clk)
        rst |=> (pc == RESET_VEC)); // R1

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(pc)); // R2

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!stall && !is_ctl) |=> (pc == $past(seq_c))); // R3

    AST_LINK_AHEAD: assert property (@(posedge clk) disable iff (rst)
        link_addr == seq_c); // R4

    AST_BEQ_MISS: assert property (@(posedge clk) disable iff (rst)
        (!stall && op == 6'd4 && rs_val != rt_val) |=> (pc == $past(seq_c))); // R5

    AST_BNE_MISS: assert property (@(posedge clk) disable iff (rst)
        (!stall && op == 6'd5 && rs_val == rt_val) |=> (pc == $past(seq_c))); // R6

    AST_REGION_JUMP: assert property (@(posedge clk) disable iff (rst)
        (!stall && (op == 6'd2 || op == 6'd3))
        |=> (pc == {$past(seq_c[31:28]), $past(instr[25:0]), 2'b00})); // R7

    AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
        (!stall && op == 6'd0 && instr[5:0] == 6'd8)
        |=> (pc == {$past(rs_val[31:2]), 2'b00})); // R8

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00); // R9
endmodule

bind pc_next_unit pcnu_checker #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .pc        (pc),
    .link_addr (link_addr)
);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] RVEC       = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs_val = '0;
    logic [31:0] rt_val = '0;
    logic [31:0] pc;
    logic [31:0] link_addr;

    int          vectors = 0;
    int          misses  = 0;
    logic [31:0] model_pc = RVEC;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pc_next_unit #(.RESET_VEC(RVEC)) u_pc_next_unit (
        .clk(clk), .rst(rst), .stall(stall), .instr(instr),
        .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_addr(link_addr)
    );

    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int op, int idx);
        return {6'(op), 26'(idx)};
    endfunction

    function automatic logic [31:0] enc_r(int rs, int funct);
        return {6'd0, 5'(rs), 15'd0, 6'(funct)};
    endfunction

    // Behavioural reference: word steps and signed offsets in plain integers
    function automatic logic [31:0] model_next(logic [31:0] cur, logic [31:0] w,
                                               logic [31:0] a, logic [31:0] b);
        longint nxt;
        longint off;
        int     op;
        op  = int'(w[31:26]);
        nxt = longint'(cur) + 4;
        off = longint'($signed(w[15:0])) * 4;
        if (op == 4 && a == b)                       nxt = nxt + off;
        else if (op == 5 && a != b)                  nxt = nxt + off;
        else if (op == 2 || op == 3)
            nxt = (nxt % 64'h1_0000_0000) / 64'h1000_0000 * 64'h1000_0000
                  + longint'(w[25:0]) * 4;
        else if (op == 0 && w[5:0] == 6'd8)          nxt = longint'(a) / 4 * 4;
        return 32'(nxt % 64'h1_0000_0000);
    endfunction

    task automatic compare(string tag, logic [31:0] exp_pc);
        vectors++;
        if (pc !== exp_pc) begin
            misses++;
            $display("FAIL %s pc actual=%08h expected=%08h", tag, pc, exp_pc);
        end
        vectors++;
        if (link_addr !== exp_pc + 32'd4) begin
            misses++;
            $display("FAIL R4 (%s) link actual=%08h expected=%08h",
                     tag, link_addr, exp_pc + 32'd4);
        end
    endtask

    task automatic apply(string tag, logic [31:0] w, logic [31:0] a,
                         logic [31:0] b, logic st);
        logic [31:0] exp_pc;
        instr = w; rs_val = a; rt_val = b; stall = st;
        exp_pc = st ? model_pc : model_next(model_pc, w, a, b);
        @(posedge clk);
        @(negedge clk);
        model_pc = exp_pc;
        compare(tag, exp_pc);
    endtask

    task automatic do_reset(string tag);
        rst = 1'b1; stall = 1'b1;
        instr = enc_j(2, 26'h123);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; stall = 1'b0;
        model_pc = RVEC;
        compare(tag, RVEC);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog expired at pc=%08h expected progress", pc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        @(posedge clk);
        @(negedge clk);
        do_reset("R1 reset vector");
        apply("R3 add steps one word",        enc_r(9, 32),         0, 0, 1'b0);
        apply("R5 beq taken forward",         enc_i(4, 9, 10, 3),   7, 7, 1'b0);
        apply("R5 beq not taken",             enc_i(4, 9, 10, 3),   1, 2, 1'b0);
        apply("R6 bne taken backward",        enc_i(5, 9, 0, -4),   1, 2, 1'b0);
        apply("R6 bne not taken",             enc_i(5, 9, 0, -4),   5, 5, 1'b0);
        apply("R3 load ignores offset",       enc_i(35, 1, 2, 100), 0, 0, 1'b0);
        apply("R8 R9 register jump aligns",   enc_r(31, 8), 32'h4000_0002, 0, 1'b0);
        apply("R7 jump in region 4",          enc_j(2, 26'h10),     0, 0, 1'b0);
        apply("R2 stall holds on jump",       enc_j(2, 26'h77),     0, 0, 1'b1);
        apply("R2 stall holds on branch",     enc_i(4, 1, 1, 9),    3, 3, 1'b1);
        apply("R7 jal to region top",         enc_j(3, 26'h3FF_FFFF), 0, 0, 1'b0);
        apply("R8 register jump to top",      enc_r(4, 8), 32'hFFFF_FFFF, 0, 1'b0);
        apply("R7 jump region wraps to 0",    enc_j(2, 5),          0, 0, 1'b0);
        apply("R5 beq offset -1 self loop",   enc_i(4, 2, 3, -1),   9, 9, 1'b0);
        apply("R3 special funct 9 steps",     enc_r(4, 9), 32'h8000_0000, 0, 1'b0);
        apply("R6 bne large positive",        enc_i(5, 1, 2, 16'h7FFF), 0, 1, 1'b0);
        do_reset("R1 reset mid run");
        apply("R3 after reset",               enc_r(0, 32),         0, 0, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule